// File: doc/BRIEF.md
# Framed Asynchronous Serial Transmitter

This block turns parallel bytes into an asynchronous serial stream. A single-byte holding stage takes a byte whenever it is empty and a write strobe is presented. The byte then moves into a shift stage, which sends it out framed. Each frame is a low start bit, then 5 to 8 data bits with the least significant first, then an optional parity bit, then a high stop period of 1, 1.5 or 2 bit times. Every bit time is sixteen pulses of an external oversampling enable, and the block does not divide the clock itself.

A 7-bit control word sets the frame format and can force a break. Break holds the line at 0 while the internal sequencing carries on as normal, so a frame sent during a break still takes its full time. Two flags report progress. The holding-empty flag doubles as the write-ready signal. The transmitter-empty flag is high only when both the holding stage and the shift stage are empty. If a byte is waiting when a stop period ends, it starts on the very next cycle, so back-to-back frames have no idle gap.

Top module: `serTx`

## Requirements
- R1: After reset, txLine is 1, holdEmpty is 1 and txEmpty is 1.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, and each bit lasts 16 baudTick pulses. lineCtrl[1:0] sets the number of data bits: 00=5, 01=6, 10=7, 11=8.
- R3: When lineCtrl[3]=1, a parity bit is sent between the last data bit and the stop period. lineCtrl[4]=0 gives odd parity over the data bits and parity bit. lineCtrl[4]=1 gives even parity.
- R4: When lineCtrl[3]=1 and lineCtrl[5]=1, the parity bit is a constant: 1 when lineCtrl[4]=0 and 0 when lineCtrl[4]=1.
- R5: The line is 1 for the whole stop period. With lineCtrl[2]=0 the stop period is 16 pulses. With lineCtrl[2]=1 it is 24 pulses for 5-bit words and 32 pulses for 6, 7 or 8-bit words.
- R6: While lineCtrl[6]=1, txLine is 0 from the next cycle on, and the frame timing is unchanged. Clearing the bit returns the line to its normal value on the next cycle.
- R7: A write (wrValid with holdEmpty=1) clears holdEmpty on the next cycle. holdEmpty sets again on the cycle after the byte moves into the shift stage.
- R8: txEmpty is 1 only when the holding stage and the shift stage are both empty. It is 0 during a frame even if holdEmpty is 1.
- R9: If a byte is waiting when the final stop pulse completes, its start bit follows at once. Two queued frames then take exactly the sum of their lengths.
- R10: A wrValid while holdEmpty=0 is ignored, and the rejected byte is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Oversampling enable, sixteen pulses per bit time |
| lineCtrl | input | 7 | Frame format and break control (fields as in R2 to R6) |
| wrData | input | 8 | Byte to transmit |
| wrValid | input | 1 | Write strobe, taken when holdEmpty is 1 |
| holdEmpty | output | 1 | Holding stage empty, also write ready |
| txEmpty | output | 1 | Holding and shift stages both empty |
| txLine | output | 1 | Serial output, idles at 1 |

## Verification
The bench counts baudTick pulses from each load to the rise of txEmpty and checks the frame length. A design that got the 1.5-stop case wrong would give 5-bit frames 16 or 32 stop pulses instead of 24. A design that let break stall the sequencer would stretch the forced-low frame. The bench sends parity frames in odd, even and both stick senses, so an inverted or unmasked parity bit shows up as a wrong mid-bit sample. A back-to-back run with an extra write into the full holding stage shows two faults: an idle gap between frames makes the total too long, and a design that accepts that write sends a third frame.

// File: rtl/serTxPkg.sv
package serTxPkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_DATA   = 3'd2,
    PH_PARITY = 3'd3,
    PH_STOP   = 3'd4
  } txPhase_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    txPhase_e phase;
  } txStrobe_t;

  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       evenSel;
    logic       parEn;
    logic       stopSel;
    logic [1:0] wordLen;
  } lineCfg_t;

endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl
  import serTxPkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic [1:0] wordLen,
  input  logic       stopSel,
  input  logic       parEn,
  input  logic       holdFull,
  output txStrobe_t  strobe
);

  localparam int TICK_W = $clog2(2 * OVS + 1);
  localparam int BIT_W  = $clog2(DATA_W);

  txPhase_e          phase;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] stopLen;
  logic [TICK_W-1:0] phaseLen;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastBit;
  logic              lastTick;
  logic              loadNow;

  always_comb begin
    if (!stopSel)
      stopLen = TICK_W'(OVS);
    else if (wordLen == 2'b00)
      stopLen = TICK_W'(OVS + OVS / 2);
    else
      stopLen = TICK_W'(2 * OVS);
  end

  assign phaseLen = (phase == PH_STOP) ? stopLen : TICK_W'(OVS);
  assign lastTick = baudTick && (tickCnt == phaseLen - 1'b1);
  assign lastBit  = BIT_W'(4) + BIT_W'(wordLen);
  assign loadNow  = holdFull &&
                    ((phase == PH_IDLE) || ((phase == PH_STOP) && lastTick));

  always_comb begin
    strobe.load  = loadNow;
    strobe.shift = (phase == PH_DATA) && lastTick;
    strobe.phase = phase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (loadNow) begin
      phase   <= PH_START;
      tickCnt <= '0;
    end else if ((phase != PH_IDLE) && baudTick) begin
      if (lastTick) begin
        tickCnt <= '0;
        case (phase)
          PH_START: begin
            phase  <= PH_DATA;
            bitCnt <= '0;
          end
          PH_DATA: begin
            if (bitCnt == lastBit)
              phase <= parEn ? PH_PARITY : PH_STOP;
            else
              bitCnt <= bitCnt + 1'b1;
          end
          PH_PARITY: phase <= PH_STOP;
          default:   phase <= PH_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < TICK_W'(2 * OVS)); // R5

  AST_STOP_LONG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_STOP) && (tickCnt >= TICK_W'(OVS))) |-> stopSel); // R5

  AST_LOAD_TO_START: assert property (@(posedge clk) disable iff (!rstN)
    loadNow |=> (phase == PH_START)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_IDLE) && !holdFull) |=> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/serTxData.sv
module serTxData
  import serTxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        wordLen,
  input  logic              brk,
  input  logic              stick,
  input  logic              evenSel,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output logic              txLine
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] dataMask;
  logic [DATA_W-1:0] maskedHold;
  logic              parBit;
  logic              parNext;
  logic              lineBit;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign dataMask[i] = (i < (5 + int'(wordLen)));
    end
  endgenerate

  assign maskedHold = holdReg & dataMask;
  assign parNext    = stick ? ~evenSel : (evenSel ? ^maskedHold : ~^maskedHold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (strobe.load) begin
      holdFull <= 1'b0;
    end else if (wrValid && !holdFull) begin
      holdReg  <= wrData;
      holdFull <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= maskedHold;
      parBit   <= parNext;
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strobe.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shiftReg[0];
      PH_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      txLine <= 1'b1;
    else
      txLine <= brk ? 1'b0 : lineBit;
  end

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    brk |=> !txLine); // R6

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.phase == PH_START) && !brk) |=> !txLine); // R2

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.phase == PH_IDLE) && !brk) |=> txLine); // R1

  AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> holdFull); // R7

  AST_LOAD_EMPTIES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> !holdFull); // R7

  AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !strobe.load) |=> (holdFull && $stable(holdReg))); // R10

endmodule

// File: rtl/serTx.sv
module serTx
  import serTxPkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [6:0]        lineCtrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  output logic              holdEmpty,
  output logic              txEmpty,
  output logic              txLine
);

  lineCfg_t  cfg;
  txStrobe_t strobe;
  logic      holdFull;

  assign cfg = lineCfg_t'(lineCtrl);

  serTxCtrl #(.OVS(OVS), .DATA_W(DATA_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baudTick (baudTick),
    .wordLen  (cfg.wordLen),
    .stopSel  (cfg.stopSel),
    .parEn    (cfg.parEn),
    .holdFull (holdFull),
    .strobe   (strobe)
  );

  serTxData #(.DATA_W(DATA_W)) dpath (
    .clk      (clk),
    .rstN     (rstN),
    .wrValid  (wrValid),
    .wrData   (wrData),
    .wordLen  (cfg.wordLen),
    .brk      (cfg.brk),
    .stick    (cfg.stick),
    .evenSel  (cfg.evenSel),
    .strobe   (strobe),
    .holdFull (holdFull),
    .txLine   (txLine)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = (strobe.phase == PH_IDLE) && !holdFull;

  AST_EMPTY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> ($past(strobe.phase) == PH_STOP)); // R8

endmodule

// File: tb/serTx_test.sv
module serTx_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic [6:0] lineCtrl = '0;
  logic [7:0] wrData = '0;
  logic       wrValid = 1'b0;
  logic       holdEmpty, txEmpty, txLine;

  serTx uut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .lineCtrl(lineCtrl),
    .wrData(wrData), .wrValid(wrValid), .holdEmpty(holdEmpty),
    .txEmpty(txEmpty), .txLine(txLine)
  );

  always #10 clk = ~clk;

  int divCnt = 0;
  always @(posedge clk) begin
    divCnt   <= (divCnt == 3) ? 0 : divCnt + 1;
    baudTick <= (divCnt == 3);
  end

  int   total = 0;
  int   bad = 0;
  logic lineAt [0:511];
  int   tickCount;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int nBits(input logic [6:0] lc);
    return 5 + int'(lc[1:0]);
  endfunction

  function automatic int stopTicks(input logic [6:0] lc);
    if (!lc[2]) return 16;
    return (lc[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frameLen(input logic [6:0] lc);
    return 16 * (1 + nBits(lc) + int'(lc[3])) + stopTicks(lc);
  endfunction

  function automatic logic parOf(input logic [6:0] lc, input logic [7:0] d);
    logic ones = 1'b0;
    for (int i = 0; i < nBits(lc); i++) ones ^= d[i];
    if (lc[5]) return ~lc[4];
    return lc[4] ? ones : ~ones;
  endfunction

  // write one byte from an idle transmitter and wait for it to enter the shifter
  task automatic startFrame(input string tag, input logic [6:0] lc, input logic [7:0] d);
    lineCtrl = lc;
    wrData   = d;
    wrValid  = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
    chk("R7", {tag, " holdEmpty after write"}, int'(holdEmpty), 0);
    chk("R8", {tag, " txEmpty after write"}, int'(txEmpty), 0);
    @(negedge clk);
    chk("R7", {tag, " holdEmpty after load"}, int'(holdEmpty), 1);
    chk("R8", {tag, " txEmpty while shifting"}, int'(txEmpty), 0);
    tickCount = 0;
  endtask

  // record line at each tick until txEmpty; optional extra writes in the first cycles
  task automatic capture(input bit doSecond, input logic [7:0] b2,
                         input bit doThird, input logic [7:0] b3);
    int iter = 0;
    while (!txEmpty && tickCount < 512) begin
      if (baudTick) begin
        lineAt[tickCount] = txLine;
        tickCount++;
      end
      wrValid = 1'b0;
      if (doSecond && iter == 0) begin wrData = b2; wrValid = 1'b1; end
      if (doThird && iter == 1) begin wrData = b3; wrValid = 1'b1; end
      iter++;
      @(negedge clk);
    end
    wrValid = 1'b0;
  endtask

  task automatic checkFrame(input string tag, input int base, input logic [6:0] lc,
                            input logic [7:0] d);
    int  n = nBits(lc);
    int  p = int'(lc[3]);
    logic forceLow = lc[6];
    chk("R2", {tag, " start bit"}, int'(lineAt[base + 8]), 0);
    for (int j = 0; j < n; j++)
      chk("R2", $sformatf("%s data bit %0d", tag, j), int'(lineAt[base + 16 * (j + 1) + 8]),
          forceLow ? 0 : int'(d[j]));
    if (p == 1)
      chk(lc[5] ? "R4" : "R3", {tag, " parity bit"}, int'(lineAt[base + 16 * (n + 1) + 8]),
          forceLow ? 0 : int'(parOf(lc, d)));
    chk("R5", {tag, " first stop sample"}, int'(lineAt[base + 16 * (n + 1 + p) + 8]),
        forceLow ? 0 : 1);
    chk("R5", {tag, " last stop tick"}, int'(lineAt[base + frameLen(lc) - 1]),
        forceLow ? 0 : 1);
  endtask

  task automatic singleFrame(input string tag, input logic [6:0] lc, input logic [7:0] d);
    startFrame(tag, lc, d);
    capture(1'b0, 8'h00, 1'b0, 8'h00);
    chk(lc[2] ? "R5" : "R2", {tag, " frame length"}, tickCount, frameLen(lc));
    checkFrame(tag, 0, lc, d);
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1", "txLine after reset", int'(txLine), 1);
    chk("R1", "holdEmpty after reset", int'(holdEmpty), 1);
    chk("R1", "txEmpty after reset", int'(txEmpty), 1);
  endtask

  task automatic testBreak();
    logic [6:0] lc = 7'h43;
    startFrame("break", lc, 8'h55);
    capture(1'b0, 8'h00, 1'b0, 8'h00);
    chk("R6", "break frame length", tickCount, frameLen(lc));
    checkFrame("break", 0, lc, 8'h55);
    lineCtrl = 7'h03;
    @(negedge clk);
    chk("R6", "line after break cleared", int'(txLine), 1);
  endtask

  task automatic testBackToBack();
    logic [6:0] lc = 7'h03;
    startFrame("b2b", lc, 8'h3C);
    capture(1'b1, 8'hC3, 1'b1, 8'hFF);
    chk("R9", "two queued frames total ticks", tickCount, 2 * frameLen(lc));
    chk("R10", "rejected write not sent", int'(tickCount <= 2 * frameLen(lc)), 1);
    checkFrame("b2b first", 0, lc, 8'h3C);
    checkFrame("b2b second", frameLen(lc), lc, 8'hC3);
    @(negedge clk);
    chk("R10", "idle after two frames", int'(txEmpty), 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    singleFrame("8N1", 7'h03, 8'hA5);
    singleFrame("5bit 1.5stop", 7'h04, 8'h13);
    singleFrame("7bit even 2stop", 7'h1E, 8'h35);
    singleFrame("6bit odd", 7'h09, 8'h2B);
    singleFrame("stick one", 7'h2B, 8'h00);
    singleFrame("stick zero", 7'h3B, 8'hFF);
    singleFrame("5bit 2stop sel", 7'h0C, 8'hE6);
    testBreak();
    testBackToBack();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule